// File: doc/BRIEF.md
# Power-Management Event Controller

This block gathers a platform's power-management events into a small register file and raises a level-sensitive system control interrupt (SCI) from them. A free-running power-management timer advances on a rate strobe. Each time the timer's top bit changes, a status flag is set. A power-button input can set a second flag when it is armed. Software clears flags by writing ones to them. An enable register chooses which flags may raise the SCI.

A control register carries a sleep command. Writing the sleep-go bit makes the block decode a three-bit sleep type. The result is either a power-off request or a wake-style reset request that also marks the wake and button flags.

A separate byte-wide port pair serves an advanced-power-management handshake. Two command codes switch the SCI-enable bit in the control register on or off. Every command write can pulse an SMI output. The second port is a plain scratch byte. All register reads are combinational on the address. Every register and the timer reset to zero.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, every register reads zero, the timer reads zero, and sci_o, smi_o, poweroff_o and reset_req_o are low.
- R2: The timer advances by one, modulo 2^TMR_W, on each clock edge where tick_i is high, and holds otherwise. A read at offset 0x08 returns the count with all upper bits zero.
- R3: Status bit 0 becomes 1 at the edge where the timer's most significant bit changes value, in either direction.
- R4: Writing status (offset 0x00) clears each bit written as 1 and leaves each bit written as 0. A flag being set at the same edge stays set.
- R5: sci_o is high exactly when status AND enable has a 1 in bit 0, 5, 8 or 10. The other bits have no effect.
- R6: Enable (offset 0x02) is a plain 16-bit register. Reads of any offset other than 0x00, 0x02, 0x04 and 0x08 return zero, and writes to them change nothing.
- R7: Control (offset 0x04) stores every written bit except bit 13, which always reads 0. A write with bit 13 = 1 and bits 12:10 = 0 gives a one-cycle poweroff_o pulse on the following cycle.
- R8: A control write with bit 13 = 1 and bits 12:10 = 1 sets status bits 15 and 8 and gives a one-cycle reset_req_o pulse. Sleep types 2 to 7 cause no request and no status change.
- R9: pwrbtn_i sets status bit 8 only while enable bit 8 is 1.
- R10: A write of 0xF1 to the APM command port (apm_sel_i = 0) sets control bit 0, and a write of 0xF0 clears it. Other codes leave it alone. The port reads back the last byte written.
- R11: Each command-port write gives a one-cycle smi_o pulse on the next cycle when smi_cfg_en_i is high, and none when it is low.
- R12: The APM status port (apm_sel_i = 1) is an 8-bit read/write register with no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer rate strobe |
| pwrbtn_i | input | 1 | Power-button event |
| smi_cfg_en_i | input | 1 | Allows SMI pulses on command writes |
| reg_addr_i | input | 6 | Register offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| apm_wr_i | input | 1 | APM port write strobe |
| apm_sel_i | input | 1 | 0 = command port, 1 = status port |
| apm_wdata_i | input | 8 | APM write data |
| apm_rdata_o | output | 8 | APM read data for apm_sel_i |
| sci_o | output | 1 | System control interrupt level |
| smi_o | output | 1 | SMI pulse |
| poweroff_o | output | 1 | Power-off request pulse |
| reset_req_o | output | 1 | Wake-style reset request pulse |

## Verification
A write, tick or button event sampled at an edge is visible on both read ports and on sci_o straight after that edge. This is because reads and the SCI are combinational from the registers. The smi_o, poweroff_o and reset_req_o pulses are registered, so they are high for exactly the one cycle after the edge that sampled the causing write. The bench updates its behavioural model at each edge and compares every output two nanoseconds later, so each result is checked in the cycle it is due. The timer width is reduced to 10 bits in the bench so that both directions of the top-bit change can be reached quickly.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] OFS_STS = 6'h00;
  localparam logic [REG_AW-1:0] OFS_EN  = 6'h02;
  localparam logic [REG_AW-1:0] OFS_CTL = 6'h04;
  localparam logic [REG_AW-1:0] OFS_TMR = 6'h08;

  localparam int STS_TMR_BIT  = 0;
  localparam int STS_BTN_BIT  = 8;
  localparam int STS_WAKE_BIT = 15;
  localparam int CTL_SCI_BIT  = 0;
  localparam int CTL_GO_BIT   = 13;
  localparam int SLP_LSB      = 10;

  localparam logic [15:0] SCI_SRC_MASK = 16'h0521;
  localparam logic [2:0]  SLP_OFF      = 3'd0;
  localparam logic [2:0]  SLP_WAKE     = 3'd1;
  localparam logic [7:0]  APM_SCI_ON   = 8'hF1;
  localparam logic [7:0]  APM_SCI_OFF  = 8'hF0;

  typedef struct packed {
    logic poweroff;
    logic wake;
  } sleep_req_t;

  function automatic logic [15:0] w1c_apply(input logic [15:0] cur,
                                            input logic [15:0] clr,
                                            input logic [15:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic sci_level(input logic [15:0] sts, input logic [15:0] en);
    return |(sts & en & SCI_SRC_MASK);
  endfunction

  function automatic sleep_req_t sleep_decode(input logic go, input logic [2:0] typ);
    sleep_req_t r;
    r.poweroff = go && (typ == SLP_OFF);
    r.wake     = go && (typ == SLP_WAKE);
    return r;
  endfunction
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [TMR_W-1:0] count_o,
  output logic             ovf_evt_o
);
  localparam int MSB = TMR_W - 1;

  logic [TMR_W-1:0] count_nxt;

  assign count_nxt = count_o + TMR_W'(1);
  // top bit flips on this tick
  assign ovf_evt_o = tick_i && (count_nxt[MSB] != count_o[MSB]);

  always_ff @(posedge clk) begin
    if (!rst_n)      count_o <= '0;
    else if (tick_i) count_o <= count_nxt;
  end
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              ovf_evt_i,
  input  logic              pwrbtn_i,
  input  logic              apm_on_i,
  input  logic              apm_off_i,
  output logic [15:0]       sts_o,
  output logic [15:0]       en_o,
  output logic [15:0]       ctl_o,
  output logic              poweroff_o,
  output logic              reset_req_o
);
  logic [15:0] sts_clr, sts_set, ctl_nxt;
  logic        wr_sts, wr_en, wr_ctl;
  sleep_req_t  slp;

  assign wr_sts = wr_i && (addr_i == OFS_STS);
  assign wr_en  = wr_i && (addr_i == OFS_EN);
  assign wr_ctl = wr_i && (addr_i == OFS_CTL);
  assign slp    = sleep_decode(wr_ctl && wdata_i[CTL_GO_BIT],
                               wdata_i[SLP_LSB +: 3]);

  always_comb begin
    sts_clr = wr_sts ? wdata_i : 16'h0000;
    sts_set = 16'h0000;
    sts_set[STS_TMR_BIT]  = ovf_evt_i;
    sts_set[STS_BTN_BIT]  = (pwrbtn_i && en_o[STS_BTN_BIT]) || slp.wake;
    sts_set[STS_WAKE_BIT] = slp.wake;
  end

  always_comb begin
    ctl_nxt = ctl_o;
    if (wr_ctl) begin
      ctl_nxt = wdata_i;
      ctl_nxt[CTL_GO_BIT] = 1'b0;
    end
    if (apm_on_i)  ctl_nxt[CTL_SCI_BIT] = 1'b1;
    if (apm_off_i) ctl_nxt[CTL_SCI_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_o       <= '0;
      en_o        <= '0;
      ctl_o       <= '0;
      poweroff_o  <= 1'b0;
      reset_req_o <= 1'b0;
    end else begin
      sts_o       <= w1c_apply(sts_o, sts_clr, sts_set);
      if (wr_en) en_o <= wdata_i;
      ctl_o       <= ctl_nxt;
      poweroff_o  <= slp.poweroff;
      reset_req_o <= slp.wake;
    end
  end
endmodule

// File: rtl/pm_apm.sv
module pm_apm
  import pm_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       sel_i,
  input  logic [7:0] wdata_i,
  input  logic       smi_cfg_en_i,
  output logic [7:0] rdata_o,
  output logic       sci_on_o,
  output logic       sci_off_o,
  output logic       smi_o
);
  logic [7:0] cmd_q, stat_q;
  logic       cmd_wr;

  assign cmd_wr    = wr_i && !sel_i;
  assign sci_on_o  = cmd_wr && (wdata_i == APM_SCI_ON);
  assign sci_off_o = cmd_wr && (wdata_i == APM_SCI_OFF);
  assign rdata_o   = sel_i ? stat_q : cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= '0;
      smi_o  <= 1'b0;
    end else begin
      if (cmd_wr)          cmd_q  <= wdata_i;
      if (wr_i && sel_i)   stat_q <= wdata_i;
      smi_o <= cmd_wr && smi_cfg_en_i;
    end
  end
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        pwrbtn_i,
  input  logic        smi_cfg_en_i,
  input  logic [5:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        apm_wr_i,
  input  logic        apm_sel_i,
  input  logic [7:0]  apm_wdata_i,
  output logic [7:0]  apm_rdata_o,
  output logic        sci_o,
  output logic        smi_o,
  output logic        poweroff_o,
  output logic        reset_req_o
);
  logic [TMR_W-1:0] tmr_q;
  logic             tmr_ovf_evt;
  logic [15:0]      sts_q, en_q, ctl_q;
  logic             apm_on, apm_off;

  pm_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .count_o(tmr_q), .ovf_evt_o(tmr_ovf_evt)
  );

  pm_apm u_apm (
    .clk(clk), .rst_n(rst_n), .wr_i(apm_wr_i), .sel_i(apm_sel_i),
    .wdata_i(apm_wdata_i), .smi_cfg_en_i(smi_cfg_en_i),
    .rdata_o(apm_rdata_o), .sci_on_o(apm_on), .sci_off_o(apm_off),
    .smi_o(smi_o)
  );

  pm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .ovf_evt_i(tmr_ovf_evt), .pwrbtn_i(pwrbtn_i),
    .apm_on_i(apm_on), .apm_off_i(apm_off),
    .sts_o(sts_q), .en_o(en_q), .ctl_o(ctl_q),
    .poweroff_o(poweroff_o), .reset_req_o(reset_req_o)
  );

  assign sci_o = sci_level(sts_q, en_q);

  always_comb begin
    unique case (reg_addr_i)
      OFS_STS: reg_rdata_o = {16'h0000, sts_q};
      OFS_EN:  reg_rdata_o = {16'h0000, en_q};
      OFS_CTL: reg_rdata_o = {16'h0000, ctl_q};
      OFS_TMR: reg_rdata_o = 32'(tmr_q);
      default: reg_rdata_o = 32'h0;
    endcase
  end
endmodule

// File: rtl/pm_event_ctrl_chk.sv
module pm_event_ctrl_chk
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             pwrbtn_i,
  input logic             smi_cfg_en_i,
  input logic [5:0]       reg_addr_i,
  input logic             reg_wr_i,
  input logic [15:0]      reg_wdata_i,
  input logic             apm_wr_i,
  input logic             apm_sel_i,
  input logic             sci_o,
  input logic             smi_o,
  input logic             poweroff_o,
  input logic             reset_req_o,
  input logic [TMR_W-1:0] tmr,
  input logic [15:0]      sts,
  input logic [15:0]      en
);
  localparam int MSB = TMR_W - 1;

  p_tmr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(tmr));

  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr[MSB] != $past(tmr[MSB])) |-> sts[STS_TMR_BIT]);

  p_sci_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & en & SCI_SRC_MASK) == 16'h0) |-> !sci_o);

  p_poweroff_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    poweroff_o |-> $past(reg_wr_i && reg_addr_i == OFS_CTL &&
                         reg_wdata_i[CTL_GO_BIT] && reg_wdata_i[12:10] == SLP_OFF));

  p_wake_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> (sts[STS_WAKE_BIT] && sts[STS_BTN_BIT]));

  p_btn_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts[STS_BTN_BIT]) && !reset_req_o) |-> $past(pwrbtn_i && en[STS_BTN_BIT]));

  p_smi_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> $past(apm_wr_i && !apm_sel_i && smi_cfg_en_i));
endmodule

bind pm_event_ctrl pm_event_ctrl_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pwrbtn_i(pwrbtn_i),
  .smi_cfg_en_i(smi_cfg_en_i), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
  .reg_wdata_i(reg_wdata_i), .apm_wr_i(apm_wr_i), .apm_sel_i(apm_sel_i),
  .sci_o(sci_o), .smi_o(smi_o), .poweroff_o(poweroff_o),
  .reset_req_o(reset_req_o), .tmr(tmr_q), .sts(sts_q), .en(en_q)
);

// File: tb/pm_event_ctrl_bench.sv
module pm_event_ctrl_bench;
  localparam int TW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, pwrbtn_i = 1'b0, smi_cfg_en_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        apm_wr_i = 1'b0, apm_sel_i = 1'b0;
  logic [7:0]  apm_wdata_i = '0;
  logic [7:0]  apm_rdata_o;
  logic        sci_o, smi_o, poweroff_o, reset_req_o;

  int checks = 0, failures = 0;
  string cur_tag = "R1";

  // behavioural model state
  int unsigned m_tmr = 0;
  int unsigned m_sts = 0, m_en = 0, m_ctl = 0, m_apmc = 0, m_apms = 0;
  bit e_smi = 0, e_off = 0, e_rst = 0;

  pm_event_ctrl #(.TMR_W(TW)) u_pm_event_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pwrbtn_i(pwrbtn_i),
    .smi_cfg_en_i(smi_cfg_en_i), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .apm_wr_i(apm_wr_i),
    .apm_sel_i(apm_sel_i), .apm_wdata_i(apm_wdata_i), .apm_rdata_o(apm_rdata_o),
    .sci_o(sci_o), .smi_o(smi_o), .poweroff_o(poweroff_o), .reset_req_o(reset_req_o)
  );

  always #4 clk = ~clk;

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int unsigned exp_read(int unsigned a);
    case (a)
      0: return m_sts;
      2: return m_en;
      4: return m_ctl;
      8: return m_tmr;
      default: return 0;
    endcase
  endfunction

  task automatic step();
    int unsigned nt, typ;
    @(posedge clk);
    nt = tick_i ? (m_tmr + 1) % (1 << TW) : m_tmr;
    e_smi = 0; e_off = 0; e_rst = 0;
    if (pwrbtn_i && m_en[8]) m_sts |= 16'h0100;
    if (reg_wr_i) begin
      case (reg_addr_i)
        6'h00: m_sts &= ~int'(reg_wdata_i);
        6'h02: m_en = reg_wdata_i;
        6'h04: begin
          m_ctl = reg_wdata_i & 16'hDFFF;
          typ = (reg_wdata_i >> 10) & 7;
          if (reg_wdata_i[13] && typ == 0) e_off = 1;
          if (reg_wdata_i[13] && typ == 1) begin e_rst = 1; m_sts |= 16'h8100; end
        end
        default: ;
      endcase
      if (pwrbtn_i && m_en[8] && reg_addr_i != 6'h02) m_sts |= 16'h0100;
    end
    if (tick_i && (((nt >> (TW-1)) & 1) != ((m_tmr >> (TW-1)) & 1))) m_sts |= 1;
    if (apm_wr_i) begin
      if (!apm_sel_i) begin
        m_apmc = apm_wdata_i;
        if (apm_wdata_i == 8'hF1) m_ctl |= 1;
        if (apm_wdata_i == 8'hF0) m_ctl &= ~1;
        e_smi = smi_cfg_en_i;
      end else m_apms = apm_wdata_i;
    end
    m_tmr = nt;
    #2;
    check(cur_tag, reg_rdata_o, exp_read(reg_addr_i));
    check(cur_tag, apm_rdata_o, apm_sel_i ? m_apms : m_apmc);
    check("R5", sci_o, (m_sts & m_en & 16'h0521) != 0);
    check("R11", smi_o, e_smi);
    check("R7", poweroff_o, e_off);
    check("R8", reset_req_o, e_rst);
  endtask

  // note: pwrbtn sets from the enable value before the edge; the model
  // above applies it before the enable write and again if no enable write.

  task automatic wr(logic [5:0] a, logic [15:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1; step(); reg_wr_i = 0;
  endtask

  task automatic rd(logic [5:0] a);
    reg_addr_i = a; step();
  endtask

  task automatic apm(logic s, logic [7:0] d);
    apm_sel_i = s; apm_wdata_i = d; apm_wr_i = 1; step(); apm_wr_i = 0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    cur_tag = "R1";
    rd(0); rd(2); rd(4); rd(8);
    apm_sel_i = 1; rd(0); apm_sel_i = 0; rd(0);

    // R6 enable rw, unmapped offsets
    cur_tag = "R6";
    wr(2, 16'hFADE); rd(2);
    wr(6, 16'h1234); rd(6); wr(6'h0A, 16'hFFFF); rd(6'h0A); rd(1); rd(6'h3F);
    rd(2);
    wr(2, 16'h0000); rd(2);

    // R2 timer counting with gaps
    cur_tag = "R2";
    reg_addr_i = 8;
    for (int i = 0; i < 40; i++) begin tick_i = (i % 3 != 1); step(); end
    tick_i = 0; repeat (3) step();

    // R3 top bit rising, R5 SCI from timer flag
    cur_tag = "R3";
    wr(2, 16'h0001); reg_addr_i = 0; tick_i = 1;
    while (m_tmr != (1 << (TW-1)) + 2) step();
    tick_i = 0; rd(0);

    // R4 write 0 keeps, write 1 clears
    cur_tag = "R4";
    wr(0, 16'hFFFE); rd(0); wr(0, 16'h0001); rd(0);
    // clear and set in the same edge
    tick_i = 1;
    while (m_tmr != (1 << TW) - 1) step();
    reg_addr_i = 0; reg_wdata_i = 16'h0001; reg_wr_i = 1; step();
    reg_wr_i = 0; tick_i = 0; rd(0);
    cur_tag = "R3"; rd(8);
    wr(0, 16'hFFFF); rd(0);

    // R9 power button gating
    cur_tag = "R9";
    wr(2, 16'h0000); pwrbtn_i = 1; step(); pwrbtn_i = 0; rd(0);
    wr(2, 16'h0100); pwrbtn_i = 1; step(); pwrbtn_i = 0; rd(0);
    cur_tag = "R5"; wr(2, 16'hFAFE); rd(0); wr(0, 16'h0100); rd(0);

    // R7 control store, power off
    cur_tag = "R7";
    wr(4, 16'h2000 | (16'd0 << 10)); rd(4); step();
    wr(4, 16'h13A5); rd(4);
    // R8 wake type and others
    cur_tag = "R8";
    wr(2, 16'h0000);
    wr(4, 16'h2000 | (16'd1 << 10)); rd(0); step(); rd(4);
    wr(0, 16'hFFFF);
    for (int t = 2; t < 8; t++) begin wr(4, 16'h2000 | 16'(t << 10)); rd(0); end
    cur_tag = "R5"; wr(2, 16'h8000); wr(4, 16'h2400); rd(0); wr(0, 16'hFFFF);

    // R10, R11 APM command port
    cur_tag = "R10";
    smi_cfg_en_i = 1; reg_addr_i = 4;
    apm(0, 8'hF1); step(); apm(0, 8'h33); step(); apm(0, 8'hF0); step();
    cur_tag = "R11";
    apm(0, 8'hF1); apm(0, 8'hF1); step();
    smi_cfg_en_i = 0; apm(0, 8'hF0); step();
    // R12 status port
    cur_tag = "R12";
    apm(1, 8'h5A); step(); apm(1, 8'hC3); apm_sel_i = 1; step();
    apm_sel_i = 0; step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule